// File: doc/BRIEF.md
# Power-Up Sequencer with Supervisory Watchdog

This block is the digital control core of a handset power-management device. While the system is off it watches three wake sources: a press of the active-low power button, a charger being plugged in, and a battery being attached. On any of these it enables the regulators and holds the active-low system reset for a programmable delay, counted in prescaled ticks. It releases reset only once the delay is over and the battery-above-reset-level input is true.

A supervisory watchdog starts counting as soon as the regulators turn on, so a battery that never climbs past the reset level gets powered down. When reset releases, the watchdog reloads itself, which gives software a full timeout for its first acknowledge. Software programs the block over a write-only three-wire serial port (chip select, clock, data). Writing a zero timeout is the shutdown command.

The block also owns several outputs whose behaviour changes at reset release:
- the oscillator enable, which it drives itself during reset and then hands to the system controller;
- the charger-indicate pin driver;
- the two measurement switches;
- the charge-switch PWM, which stays forced on until software first writes it.

Top module: `pwr_seq_core`

## Requirements
- R1: While off, a falling edge on `pwr_btn_n`, a rising edge on `chg_present` or a rising edge on `batt_present` sets `reg_en` high with `sys_rst_n` low, within four clocks.
- R2: `sys_rst_n` rises on the clock after the later of two events: the POR_TICKS-th tick since entry to reset, and `batt_ok` going high. It stays low while `batt_ok` is low.
- R3: The watchdog counts ticks during reset as well. When the timeout runs out before release, `reg_en` drops on the clock of the expiring tick.
- R4: Release reloads the watchdog, so the system powers off on exactly the limit-th tick after release if nothing else acknowledges it. The limit is code × WD_SCALE ticks and the code defaults to WD_DEFAULT.
- R5: A write of a nonzero code to address 1 stores that code and reloads the watchdog. A reload that lands on the clock of the expiring tick wins, and no power-off occurs.
- R6: A write of zero to address 1 powers the system off on the next clock and leaves the stored code unchanged.
- R7: After a power-off the block stays off until a new wake edge arrives. A wake input held at its active level does not restart it.
- R8: `pwm_out` is forced high during reset and after release until the first write to address 3. After that it is high while a tick-driven 8-bit counter is below the written duty, so duty 0 gives low. Every power-up forces it high again.
- R9: `osc_en` is high during reset and follows `asic_osc_en` while running.
- R10: `chg_ind_oe` and `chg_ind_out` are low until release. While running, `chg_ind_oe` is high and `chg_ind_out` follows `chg_present`.
- R11: Both measurement switches are open outside the running state. While running, `meas_bat_sw` follows bit 0 and `meas_chg_sw` follows bit 1 of address 2.
- R12: A frame is 16 bits, shifted MSB first on `sc_clk` rising while `sc_cs_n` is low. It holds address[15:12], ignored bits [11:8] and data[7:0], and commits on `sc_cs_n` rising. Frames of any other length, unknown addresses, and any frame that arrives while not running are ignored.
- R13: Register contents survive power-off and power-up and are cleared only by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block supply reset, active low |
| tick | input | 1 | Prescaled time-base strobe |
| pwr_btn_n | input | 1 | Power button, active low |
| chg_present | input | 1 | Charger detected |
| batt_present | input | 1 | Battery attached |
| batt_ok | input | 1 | Battery above reset level |
| asic_osc_en | input | 1 | Oscillator enable request from system controller |
| sc_cs_n | input | 1 | Serial chip select, active low |
| sc_clk | input | 1 | Serial clock |
| sc_data | input | 1 | Serial data |
| reg_en | output | 1 | Regulator enable |
| sys_rst_n | output | 1 | System reset, active low |
| osc_en | output | 1 | Reference oscillator enable |
| pwm_out | output | 1 | Charge-switch PWM |
| meas_bat_sw | output | 1 | Battery-to-ADC switch closed |
| meas_chg_sw | output | 1 | Charger-to-ADC switch closed |
| chg_ind_oe | output | 1 | Charger-indicate pin output enable |
| chg_ind_out | output | 1 | Charger-indicate pin output value |

## Verification
A watchdog acknowledge write and the tick that would expire the watchdog can land on the same clock. The bench brings the counter to one tick short of its limit. It then raises `tick` only in the cycle in which the frame commits, counted from the chip-select rise through the input synchronizer. The design passes when `reg_en` stays high and exactly the newly written limit of ticks is needed before power-off. A second pairing, expiry against release, is judged through the reset-phase expiry case.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned RSV_W   = 4;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = ADDR_W + RSV_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADR_WDOG = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_MEAS = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_PWM  = 4'd3;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RESET = 2'd1,
    ST_RUN   = 2'd2
  } pwr_state_t;

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1 -: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] frame_data(input logic [FRAME_W-1:0] f);
    return f[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_seq_serial.sv
module pwr_seq_serial
  import pwr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               cs_p, sclk_p;
  logic               sclk_rise, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_p & ~cs_n_s;
  assign cs_rise   = cs_n_s & ~cs_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      cs_p    <= 1'b1;
      sclk_p  <= 1'b0;
    end else begin
      cs_p   <= cs_n_s;
      sclk_p <= sclk_s;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdata_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign wr_stb  = cs_rise && (bit_cnt == CNT_W'(FRAME_W));
  assign wr_addr = frame_addr(shreg);
  assign wr_data = frame_data(shreg);
endmodule

// File: rtl/pwr_seq_tick_cnt.sv
module pwr_seq_tick_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit,
  output logic         done
);
  logic [W-1:0] cnt;
  logic [W:0]   nxt;

  assign nxt  = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  assign done = (cnt >= limit);
  assign hit  = tick & ~done & (nxt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (tick && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_core.sv
module pwr_seq_core
  import pwr_seq_pkg::*;
#(
  parameter int unsigned POR_TICKS  = 100,
  parameter int unsigned WD_SCALE   = 250,
  parameter int unsigned WD_DEFAULT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_btn_n,
  input  logic chg_present,
  input  logic batt_present,
  input  logic batt_ok,
  input  logic asic_osc_en,
  input  logic sc_cs_n,
  input  logic sc_clk,
  input  logic sc_data,
  output logic reg_en,
  output logic sys_rst_n,
  output logic osc_en,
  output logic pwm_out,
  output logic meas_bat_sw,
  output logic meas_chg_sw,
  output logic chg_ind_oe,
  output logic chg_ind_out
);
  localparam int unsigned POR_W = $clog2(POR_TICKS + 1);
  localparam int unsigned WD_W  = $clog2(((1 << DATA_W) - 1) * WD_SCALE + 1);

  function automatic logic [WD_W-1:0] wd_limit(input logic [DATA_W-1:0] code);
    return WD_W'(32'(code) * WD_SCALE);
  endfunction

  // synchronized inputs: {batt_present, chg_present, pwr_btn_n}
  logic [2:0] wake_s, wake_p;
  logic [2:0] bus_s;
  logic       wake_evt;

  pwr_seq_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) u_sync_wake (
    .clk(clk), .rst_n(rst_n),
    .d({batt_present, chg_present, pwr_btn_n}), .q(wake_s));

  pwr_seq_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync_bus (
    .clk(clk), .rst_n(rst_n),
    .d({sc_cs_n, sc_clk, sc_data}), .q(bus_s));

  assign wake_evt = (~wake_s[0] & wake_p[0]) |
                    ( wake_s[1] & ~wake_p[1]) |
                    ( wake_s[2] & ~wake_p[2]);

  // serial write port
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  pwr_seq_serial u_serial (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(bus_s[2]), .sclk_s(bus_s[1]), .sdata_s(bus_s[0]),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  // state and registers
  pwr_state_t        state_q, state_d;
  logic [DATA_W-1:0] wd_code, pwm_duty, pwm_cnt;
  logic [1:0]        meas_q;
  logic              pwm_forced;

  logic wr_ok, ack_wr, shut_cmd, release_now;
  logic wd_clr, wd_hit, wd_expire, por_done, por_hit;

  assign wr_ok       = wr_stb && (state_q == ST_RUN);
  assign ack_wr      = wr_ok && (wr_addr == ADR_WDOG) && (wr_data != '0);
  assign shut_cmd    = wr_ok && (wr_addr == ADR_WDOG) && (wr_data == '0);
  assign release_now = (state_q == ST_RESET) && por_done && batt_ok;
  assign wd_clr      = (state_q == ST_OFF) || release_now || ack_wr;
  assign wd_expire   = (state_q != ST_OFF) && wd_hit && !ack_wr;

  pwr_seq_tick_cnt #(.W(POR_W)) u_por_cnt (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_RESET), .tick(tick),
    .limit(POR_W'(POR_TICKS)), .hit(por_hit), .done(por_done));

  pwr_seq_tick_cnt #(.W(WD_W)) u_wd_cnt (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .tick(tick),
    .limit(wd_limit(wd_code)), .hit(wd_hit), .done());

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (wake_evt) state_d = ST_RESET;
      ST_RESET: if (wd_expire) state_d = ST_OFF;
                else if (release_now) state_d = ST_RUN;
      ST_RUN:   if (wd_expire || shut_cmd) state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OFF;
      wake_p     <= 3'b001;
      wd_code    <= DATA_W'(WD_DEFAULT);
      pwm_duty   <= '0;
      pwm_cnt    <= '0;
      meas_q     <= '0;
      pwm_forced <= 1'b1;
    end else begin
      state_q <= state_d;
      wake_p  <= wake_s;
      if (tick) pwm_cnt <= pwm_cnt + 1'b1;
      if ((state_q == ST_OFF) && wake_evt) pwm_forced <= 1'b1;
      if (wr_ok) begin
        unique case (wr_addr)
          ADR_WDOG: if (wr_data != '0) wd_code <= wr_data;
          ADR_MEAS: meas_q <= wr_data[1:0];
          ADR_PWM: begin
            pwm_duty   <= wr_data;
            pwm_forced <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // outputs whose owner changes at release
  logic running;
  assign running     = (state_q == ST_RUN);
  assign reg_en      = (state_q != ST_OFF);
  assign sys_rst_n   = running;
  assign osc_en      = (state_q == ST_RESET) | (running & asic_osc_en);
  assign pwm_out     = reg_en & (pwm_forced | (pwm_cnt < pwm_duty));
  assign meas_bat_sw = running & meas_q[0];
  assign meas_chg_sw = running & meas_q[1];
  assign chg_ind_oe  = running;
  assign chg_ind_out = running & wake_s[1];

  logic unused_por_hit;
  assign unused_por_hit = por_hit;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic batt_ok,
  input logic asic_osc_en,
  input logic reg_en,
  input logic sys_rst_n,
  input logic osc_en,
  input logic pwm_out,
  input logic meas_bat_sw,
  input logic meas_chg_sw,
  input logic chg_ind_oe,
  input logic chg_ind_out,
  input logic wd_expire,
  input logic shut_cmd
);
  p_wake_holds_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en) |-> !sys_rst_n);
  p_run_needs_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |-> reg_en);
  p_release_needs_batt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(batt_ok));
  p_expire_powers_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !reg_en);
  p_shutdown_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shut_cmd |=> !reg_en);
  p_pwm_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !sys_rst_n) |-> pwm_out);
  p_osc_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !sys_rst_n) |-> osc_en);
  p_osc_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |-> (osc_en == asic_osc_en));
  p_chg_pin_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> (!chg_ind_oe && !chg_ind_out));
  p_meas_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> (!meas_bat_sw && !meas_chg_sw));
endmodule

bind pwr_seq_core pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .batt_ok(batt_ok), .asic_osc_en(asic_osc_en),
  .reg_en(reg_en), .sys_rst_n(sys_rst_n), .osc_en(osc_en), .pwm_out(pwm_out),
  .meas_bat_sw(meas_bat_sw), .meas_chg_sw(meas_chg_sw),
  .chg_ind_oe(chg_ind_oe), .chg_ind_out(chg_ind_out),
  .wd_expire(wd_expire), .shut_cmd(shut_cmd));

// File: tb/pwr_seq_core_tb.sv
module pwr_seq_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POR_T  = 6;
  localparam int SCALE  = 2;
  localparam int WD_DEF = 8;

  function automatic int wd_ticks(input int code);
    return code * SCALE;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, pwr_btn_n = 1'b1, chg_present = 1'b0, batt_present = 1'b0;
  logic batt_ok = 1'b0, asic_osc_en = 1'b0;
  logic sc_cs_n = 1'b1, sc_clk = 1'b0, sc_data = 1'b0;
  logic reg_en, sys_rst_n, osc_en, pwm_out, meas_bat_sw, meas_chg_sw;
  logic chg_ind_oe, chg_ind_out;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_core #(.POR_TICKS(POR_T), .WD_SCALE(SCALE), .WD_DEFAULT(WD_DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_btn_n(pwr_btn_n),
    .chg_present(chg_present), .batt_present(batt_present), .batt_ok(batt_ok),
    .asic_osc_en(asic_osc_en), .sc_cs_n(sc_cs_n), .sc_clk(sc_clk), .sc_data(sc_data),
    .reg_en(reg_en), .sys_rst_n(sys_rst_n), .osc_en(osc_en), .pwm_out(pwm_out),
    .meas_bat_sw(meas_bat_sw), .meas_chg_sw(meas_chg_sw),
    .chg_ind_oe(chg_ind_oe), .chg_ind_out(chg_ind_out));

  // {frame, expected meas_bat_sw, meas_chg_sw, pwm_out}
  localparam logic [18:0] VEC [7] = '{
    {16'h2001, 3'b101},
    {16'h2003, 3'b111},
    {16'h2002, 3'b011},
    {16'h3000, 3'b010},
    {16'h2F01, 3'b100},
    {16'h5003, 3'b100},
    {16'h2000, 3'b000}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick = 1'b1;
      step(1);
      tick = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [31:0] bits, input int n, input bit tick_at_commit);
    sc_cs_n = 1'b0;
    step(4);
    for (int i = 0; i < n; i++) begin
      sc_data = bits[31-i];
      step(4);
      sc_clk = 1'b1;
      step(4);
      sc_clk = 1'b0;
    end
    step(4);
    sc_cs_n = 1'b1;
    if (tick_at_commit) begin
      step(2);
      tick = 1'b1;
      step(1);
      tick = 1'b0;
      step(3);
    end else begin
      step(6);
    end
  endtask

  task automatic release_after_por();
    ticks(POR_T);
    chk("R2 held until delay done", sys_rst_n, 1'b0);
    step(1);
    chk("R2 release", sys_rst_n, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("R1 reset reg_en", reg_en, 1'b0);
    chk("R1 reset sys_rst_n", sys_rst_n, 1'b0);
    chk("R8 off pwm", pwm_out, 1'b0);
    chk("R10 off oe", chg_ind_oe, 1'b0);

    // button wake
    pwr_btn_n = 1'b0;
    step(4);
    chk("R1 button wake", reg_en, 1'b1);
    chk("R1 reset held", sys_rst_n, 1'b0);
    chk("R8 forced in reset", pwm_out, 1'b1);
    chk("R9 osc high in reset", osc_en, 1'b1);
    chk("R10 pin input in reset", chg_ind_oe, 1'b0);
    chk("R11 bat open in reset", meas_bat_sw, 1'b0);
    ticks(POR_T);
    step(2);
    chk("R2 waits for batt_ok", sys_rst_n, 1'b0);
    batt_ok = 1'b1;
    step(1);
    chk("R2 release on batt_ok", sys_rst_n, 1'b1);
    pwr_btn_n = 1'b1;
    step(1);
    chk("R9 follow low", osc_en, 1'b0);
    asic_osc_en = 1'b1;
    step(1);
    chk("R9 follow high", osc_en, 1'b1);
    chg_present = 1'b1;
    step(4);
    chk("R10 oe after release", chg_ind_oe, 1'b1);
    chk("R10 drives charger", chg_ind_out, 1'b1);
    chg_present = 1'b0;
    step(4);
    chk("R10 drives no charger", chg_ind_out, 1'b0);

    // internal ack at release: full default timeout
    ticks(wd_ticks(WD_DEF) - 1);
    chk("R4 still on before limit", reg_en, 1'b1);
    ticks(1);
    chk("R4 off at limit", reg_en, 1'b0);
    step(10);
    chk("R7 stays off", reg_en, 1'b0);

    // charger wake, expiry during reset
    batt_ok = 1'b0;
    chg_present = 1'b1;
    step(4);
    chk("R1 charger wake", reg_en, 1'b1);
    ticks(wd_ticks(WD_DEF) - 1);
    chk("R3 counting in reset", reg_en, 1'b1);
    ticks(1);
    chk("R3 expire in reset", reg_en, 1'b0);
    step(10);
    chk("R7 held charger no rewake", reg_en, 1'b0);
    chg_present = 1'b0;
    step(4);
    chg_present = 1'b1;
    step(4);
    chk("R7 reinsert wakes", reg_en, 1'b1);
    batt_ok = 1'b1;
    release_after_por();

    // table of register writes
    for (int v = 0; v < 7; v++) begin
      send_frame({VEC[v][18:3], 16'h0}, 16, 1'b0);
      chk($sformatf("R11 vec%0d bat", v), meas_bat_sw, VEC[v][2]);
      chk($sformatf("R11 vec%0d chg", v), meas_chg_sw, VEC[v][1]);
      chk($sformatf("R8 vec%0d pwm", v), pwm_out, VEC[v][0]);
    end

    // wrong lengths
    send_frame({16'h2003, 16'h0}, 15, 1'b0);
    chk("R12 short frame dropped", meas_bat_sw, 1'b0);
    send_frame({16'h2003, 16'h0}, 17, 1'b0);
    chk("R12 long frame dropped", meas_chg_sw, 1'b0);
    send_frame({16'h2003, 16'h0}, 16, 1'b0);
    chk("R12 good frame", meas_chg_sw, 1'b1);

    // ack coincident with expiring tick
    send_frame({16'h1003, 16'h0}, 16, 1'b0);
    ticks(wd_ticks(3) - 1);
    chk("R5 new limit not yet", reg_en, 1'b1);
    send_frame({16'h1004, 16'h0}, 16, 1'b1);
    chk("R5 ack wins over expiry", reg_en, 1'b1);
    ticks(wd_ticks(4) - 1);
    chk("R5 full reload", reg_en, 1'b1);

    // shutdown command
    send_frame({16'h1000, 16'h0}, 16, 1'b0);
    chk("R6 shutdown", reg_en, 1'b0);

    // battery wake, persistence
    batt_present = 1'b1;
    step(4);
    chk("R1 battery wake", reg_en, 1'b1);
    chk("R8 reforced", pwm_out, 1'b1);
    chk("R11 open in reset", meas_chg_sw, 1'b0);
    release_after_por();
    chk("R13 bat bit kept", meas_bat_sw, 1'b1);
    chk("R13 chg bit kept", meas_chg_sw, 1'b1);
    ticks(wd_ticks(4) - 1);
    chk("R6 code kept before limit", reg_en, 1'b1);
    ticks(1);
    chk("R6 code kept at limit", reg_en, 1'b0);

    // frame while off is ignored
    send_frame({16'h2000, 16'h0}, 16, 1'b0);
    pwr_btn_n = 1'b0;
    step(4);
    pwr_btn_n = 1'b1;
    release_after_por();
    chk("R12 off-state frame ignored", meas_bat_sw, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule